// File: doc/BRIEF.md
# UART Character Queue with Fill-Level Triggers

This block is the character queue that sits between a UART's shift logic and the host side. It holds up to 64 characters in arrival order. The receive variant stores three error-status bits next to each data byte. The transmit variant stores the byte alone. From the fill level it derives an interrupt request and a DMA-ready indication. For the receive variant the threshold is counted in stored characters. For the transmit variant it is counted in free places.

The threshold comes from one of two sources. A two-bit preset code selects one of four fixed levels. A four-bit programmable value, when nonzero, overrides the code in steps of four entries. When the queue is switched off it behaves as a single-character holding register with a threshold of one. Reset leaves the queue in that mode. A flush input, or any change of the enable bit, empties the queue in one cycle and clears the sticky overrun flag.

Top module: `uart_trig_fifo`

## Requirements
- R1: After reset, count is 0, overrun is 0 and the queue is in one-entry mode. The receive variant shows irq=0 and dma_rdy=0. The transmit variant shows irq=1 and dma_rdy=1.
- R2: With fifo_en=1 the queue accepts 64 entries and returns them first-in first-out. The receive variant returns each byte together with the 3-bit status written with it. The transmit variant returns status 0.
- R3: With fifo_en=0 the capacity is one entry and the threshold is one.
- R4: When prog_trig is nonzero and fifo_en=1, the threshold is 4 × prog_trig entries.
- R5: When prog_trig is 0 and fifo_en=1, trig_sel selects the threshold. For the receive variant the codes 0, 1, 2 and 3 give 8, 16, 56 and 60. For the transmit variant they give 8, 16, 32 and 56.
- R6: The receive variant's irq is 1 exactly when count ≥ threshold. The transmit variant's irq is 1 exactly when (capacity − count) ≥ threshold.
- R7: dma_rdy rises together with irq and then stays high until the release point. For the receive variant that point is an empty queue. For the transmit variant it is a full queue.
- R8: A push into a full queue without a pop in the same cycle is dropped. The count does not change and overrun becomes 1. Overrun stays 1 until a clear.
- R9: A pop from an empty queue leaves rd_data, rd_stat and count unchanged.
- R10: flush=1 makes count 0 and overrun 0 on the next cycle. A push in the same cycle is discarded.
- R11: A cycle in which fifo_en differs from its value on the previous cycle clears the queue the same way flush does.
- R12: A push and a pop in the same cycle on a non-empty queue both take effect, even when the queue is full, and count is unchanged. On an empty queue only the push takes effect.
- R13: rd_data and rd_stat take the head entry one cycle after an accepted pop and hold it until the next accepted pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 = 64-entry queue, 0 = one-entry holding register |
| trig_sel | input | 2 | Preset threshold code |
| prog_trig | input | 4 | Programmable threshold in steps of 4; 0 selects the preset |
| flush | input | 1 | Empty the queue and clear overrun |
| push | input | 1 | Write strobe |
| wr_data | input | 8 | Byte to store |
| wr_stat | input | 3 | Error status to store (receive variant) |
| pop | input | 1 | Read strobe |
| rd_data | output | 8 | Last byte read |
| rd_stat | output | 3 | Status of the last byte read |
| count | output | 7 | Entries held |
| overrun | output | 1 | Sticky: a push was dropped |
| irq | output | 1 | Threshold interrupt |
| dma_rdy | output | 1 | DMA-ready indication with hold |

## Verification
A push and a pop can arrive in the same cycle, and the outcome depends on the fill level. On a full queue both must be accepted without raising overrun. On an empty queue only the push may count. The bench drives both strobes together in each of these states and then checks count, overrun and the byte returned on the following cycles. It also drives a push together with a flush, and a push together with an enable change, and checks that the clear wins.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  localparam int SEL_W = 2;

  // Fixed thresholds per preset code; receive counts stored entries,
  // transmit counts free places.
  function automatic int unsigned preset_level(input bit is_rx,
                                               input logic [SEL_W-1:0] code);
    int unsigned lvl;
    if (is_rx) begin
      case (code)
        2'd0:    lvl = 8;
        2'd1:    lvl = 16;
        2'd2:    lvl = 56;
        default: lvl = 60;
      endcase
    end else begin
      case (code)
        2'd0:    lvl = 8;
        2'd1:    lvl = 16;
        2'd2:    lvl = 32;
        default: lvl = 56;
      endcase
    end
    return lvl;
  endfunction

endpackage

// File: rtl/uart_fifo_store.sv
module uart_fifo_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 11,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             clr,
  input  logic             cap_one,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wr_word,
  output logic [WIDTH-1:0] rd_word,
  output logic [CNT_W-1:0] count,
  output logic             overrun
);

  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cap;
  logic             ovr_q, ovr_d;
  logic [WIDTH-1:0] rd_q;
  logic             full, empty, do_push, do_pop, drop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_P) ? '0 : p + PTR_W'(1);
  endfunction

  assign cap     = cap_one ? ONE_C : FULL_C;
  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q >= cap);
  assign do_pop  = pop & ~empty & ~clr;
  assign do_push = push & ~clr & (~full | do_pop);
  assign drop    = push & ~clr & full & ~do_pop;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    ovr_d = ovr_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
      ovr_d = 1'b0;
    end else begin
      if (do_push) wp_d = ptr_inc(wp_q);
      if (do_pop)  rp_d = ptr_inc(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + CNT_W'(1);
        2'b01:   cnt_d = cnt_q - CNT_W'(1);
        default: cnt_d = cnt_q;
      endcase
      if (drop) ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     rd_q <= '0;
    else if (do_pop) rd_q <= mem_q[rp_q];
  end

  assign rd_word = rd_q;
  assign count   = cnt_q;
  assign overrun = ovr_q;

  assert_cap_bound_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    !clr |-> (count <= cap));
  assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (push && !pop && full && !clr) |=> ($stable(count) && overrun));
  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (overrun && !clr) |=> overrun);
  assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (pop && !push && empty && !clr) |=> ($stable(rd_word) && count == '0));
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    clr |=> (count == '0 && !overrun));
  assert_pair_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    (push && pop && !empty && !clr) |=> $stable(count));
  assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_ni)
    !(pop && !empty && !clr) |=> $stable(rd_word));

endmodule

// File: rtl/uart_trig_level.sv
module uart_trig_level
  import uart_fifo_pkg::*;
#(
  parameter bit IS_RX     = 1'b1,
  parameter int DEPTH     = 64,
  parameter int PROG_W    = 4,
  parameter int TRIG_UNIT = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              fifo_en,
  input  logic [SEL_W-1:0]  trig_sel,
  input  logic [PROG_W-1:0] prog_trig,
  output logic [CNT_W-1:0]  level
);

  int unsigned lvl;

  always_comb begin
    if (!fifo_en)            lvl = 1;
    else if (prog_trig != '0) lvl = int'(prog_trig) * TRIG_UNIT;
    else                     lvl = preset_level(IS_RX, trig_sel);
  end

  assign level = CNT_W'(lvl);

endmodule

// File: rtl/uart_fifo_flags.sv
module uart_fifo_flags #(
  parameter bit IS_RX = 1'b1,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             clr,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] cap,
  input  logic [CNT_W-1:0] level,
  output logic             irq,
  output logic             dma_rdy
);

  logic             hit, rel, dma_q, dma_d;
  logic [CNT_W-1:0] space;

  assign space = (count >= cap) ? '0 : cap - count;

  if (IS_RX) begin : g_rx
    assign hit = (count >= level);
    assign rel = (count == '0);

    assert_rx_release_R7: assert property (@(posedge clk) disable iff (!rst_ni)
      $fell(dma_rdy) |-> (count == '0 || $past(clr)));
  end else begin : g_tx
    assign hit = (space >= level);
    assign rel = (count >= cap);

    assert_tx_release_R7: assert property (@(posedge clk) disable iff (!rst_ni)
      $fell(dma_rdy) |-> (count >= cap || $past(clr)));
  end

  always_comb begin
    dma_d = clr ? 1'b0 : dma_rdy;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) dma_q <= 1'b0;
    else         dma_q <= dma_d;
  end

  assign irq     = hit;
  assign dma_rdy = hit | (dma_q & ~rel);

  assert_irq_dma_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |-> dma_rdy);

endmodule

// File: rtl/uart_trig_fifo.sv
module uart_trig_fifo
  import uart_fifo_pkg::*;
#(
  parameter bit IS_RX     = 1'b1,
  parameter int DEPTH     = 64,
  parameter int DATA_W    = 8,
  parameter int STAT_W    = 3,
  parameter int PROG_W    = 4,
  parameter int TRIG_UNIT = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic [SEL_W-1:0]  trig_sel,
  input  logic [PROG_W-1:0] prog_trig,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [STAT_W-1:0] wr_stat,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic [STAT_W-1:0] rd_stat,
  output logic [CNT_W-1:0]  count,
  output logic              overrun,
  output logic              irq,
  output logic              dma_rdy
);

  localparam int WORD_W = DATA_W + (IS_RX ? STAT_W : 0);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

  logic [1:0]        rs_q;
  logic              rst_i;
  logic              en_q;
  logic              clr;
  logic [CNT_W-1:0]  cap, level, cnt;
  logic [WORD_W-1:0] wr_word, rd_word;

  // Reset: asserted at once, released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) en_q <= 1'b0;
    else        en_q <= fifo_en;
  end

  assign clr = flush | (fifo_en ^ en_q);
  assign cap = fifo_en ? FULL_C : ONE_C;

  if (IS_RX) begin : g_rx_word
    assign wr_word = {wr_stat, wr_data};
    assign rd_data = rd_word[DATA_W-1:0];
    assign rd_stat = rd_word[WORD_W-1:DATA_W];
  end else begin : g_tx_word
    assign wr_word = wr_data;
    assign rd_data = rd_word;
    assign rd_stat = '0;
  end

  uart_fifo_store #(
    .DEPTH (DEPTH),
    .WIDTH (WORD_W)
  ) u_store (
    .clk     (clk),
    .rst_ni  (rst_i),
    .clr     (clr),
    .cap_one (~fifo_en),
    .push    (push),
    .pop     (pop),
    .wr_word (wr_word),
    .rd_word (rd_word),
    .count   (cnt),
    .overrun (overrun)
  );

  uart_trig_level #(
    .IS_RX     (IS_RX),
    .DEPTH     (DEPTH),
    .PROG_W    (PROG_W),
    .TRIG_UNIT (TRIG_UNIT)
  ) u_level (
    .fifo_en   (fifo_en),
    .trig_sel  (trig_sel),
    .prog_trig (prog_trig),
    .level     (level)
  );

  uart_fifo_flags #(
    .IS_RX (IS_RX),
    .CNT_W (CNT_W)
  ) u_flags (
    .clk     (clk),
    .rst_ni  (rst_i),
    .clr     (clr),
    .count   (cnt),
    .cap     (cap),
    .level   (level),
    .irq     (irq),
    .dma_rdy (dma_rdy)
  );

  assign count = cnt;

  assert_level_range_R4: assert property (@(posedge clk) disable iff (!rst_i)
    (level != '0) && (level <= cap));
  assert_mode_clear_R11: assert property (@(posedge clk) disable iff (!rst_i)
    (fifo_en != en_q) |=> (count == '0 && !overrun));
  assert_one_entry_R3: assert property (@(posedge clk) disable iff (!rst_i)
    (!fifo_en && en_q == fifo_en) |-> (count <= ONE_C));

endmodule

// File: tb/uart_trig_fifo_tb.sv
module uart_trig_fifo_tb;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fifo_en, flush, push, pop;
  logic [1:0] trig_sel;
  logic [3:0] prog_trig;
  logic [7:0] wr_data;
  logic [2:0] wr_stat;

  logic [7:0] rx_data, tx_data;
  logic [2:0] rx_stat, tx_stat;
  logic [6:0] rx_cnt, tx_cnt;
  logic       rx_ovr, tx_ovr, rx_irq, tx_irq, rx_dma, tx_dma;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P / 2) clk = ~clk;

  uart_trig_fifo #(.IS_RX(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
    .prog_trig(prog_trig), .flush(flush), .push(push), .wr_data(wr_data),
    .wr_stat(wr_stat), .pop(pop), .rd_data(rx_data), .rd_stat(rx_stat),
    .count(rx_cnt), .overrun(rx_ovr), .irq(rx_irq), .dma_rdy(rx_dma));

  uart_trig_fifo #(.IS_RX(1'b0)) u_dut_tx (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
    .prog_trig(prog_trig), .flush(flush), .push(push), .wr_data(wr_data),
    .wr_stat(wr_stat), .pop(pop), .rd_data(tx_data), .rd_stat(tx_stat),
    .count(tx_cnt), .overrun(tx_ovr), .irq(tx_irq), .dma_rdy(tx_dma));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic ps, input logic pp, input logic fl,
                      input logic [7:0] d, input logic [2:0] s);
    push = ps; pop = pp; flush = fl; wr_data = d; wr_stat = s;
    @(negedge clk);
    push = 1'b0; pop = 1'b0; flush = 1'b0;
  endtask

  function automatic int lvl_rx(input int p, input int s);
    if (p != 0) return 4 * p;
    case (s)
      0: return 8;
      1: return 16;
      2: return 56;
      default: return 60;
    endcase
  endfunction

  function automatic int lvl_tx(input int p, input int s);
    if (p != 0) return 4 * p;
    case (s)
      0: return 8;
      1: return 16;
      2: return 32;
      default: return 56;
    endcase
  endfunction

  task automatic t_reset();
    chk("R1 count", rx_cnt, 0);
    chk("R1 overrun", rx_ovr, 0);
    chk("R1 rx irq", rx_irq, 0);
    chk("R1 rx dma", rx_dma, 0);
    chk("R1 tx irq", tx_irq, 1);
    chk("R1 tx dma", tx_dma, 1);
  endtask

  task automatic t_disabled();
    step(1, 0, 0, 8'hA5, 3'd5);
    chk("R3 count one", rx_cnt, 1);
    chk("R3 rx irq at one", rx_irq, 1);
    chk("R3 tx irq no space", tx_irq, 0);
    step(1, 0, 0, 8'h3C, 3'd1);
    chk("R8 dropped count", rx_cnt, 1);
    chk("R8 overrun set", rx_ovr, 1);
    step(0, 1, 0, 8'h00, 3'd0);
    chk("R13 rd data", rx_data, 8'hA5);
    chk("R13 rd stat", rx_stat, 5);
    chk("R8 overrun sticky", rx_ovr, 1);
    chk("R3 count zero", rx_cnt, 0);
  endtask

  task automatic t_pop_empty();
    step(0, 1, 0, 8'h00, 3'd0);
    chk("R9 data kept", rx_data, 8'hA5);
    chk("R9 stat kept", rx_stat, 5);
    chk("R9 count kept", rx_cnt, 0);
  endtask

  task automatic t_flush();
    step(0, 0, 1, 8'h00, 3'd0);
    chk("R10 overrun cleared", rx_ovr, 0);
    step(1, 0, 1, 8'h11, 3'd1);
    chk("R10 flush beats push", rx_cnt, 0);
  endtask

  task automatic t_fill();
    fifo_en = 1'b1; prog_trig = 4'd0; trig_sel = 2'd1;
    step(0, 0, 0, 8'h00, 3'd0);
    for (int i = 0; i < 64; i++) begin
      step(1, 0, 0, 8'(i), 3'(i % 8));
      if (i + 1 == 15) chk("R6 rx below level", rx_irq, 0);
      if (i + 1 == 16) begin
        chk("R6 rx at level", rx_irq, 1);
        chk("R7 rx dma rise", rx_dma, 1);
      end
      if (i + 1 == 48) chk("R6 tx space at level", tx_irq, 1);
      if (i + 1 == 49) begin
        chk("R6 tx space below", tx_irq, 0);
        chk("R7 tx dma held", tx_dma, 1);
      end
    end
    chk("R2 count full", rx_cnt, 64);
    chk("R7 tx dma released at full", tx_dma, 0);
    chk("R8 no overrun yet", rx_ovr, 0);
    step(1, 0, 0, 8'h99, 3'd6);
    chk("R8 full push dropped", rx_cnt, 64);
    chk("R8 overrun on full", rx_ovr, 1);
    step(1, 1, 0, 8'h77, 3'd7);
    chk("R12 pair on full count", rx_cnt, 64);
    chk("R12 pair on full data", rx_data, 0);
    for (int k = 0; k < 64; k++) begin
      step(0, 1, 0, 8'h00, 3'd0);
      chk("R2 order data", rx_data, (k < 63) ? k + 1 : 8'h77);
      chk("R2 order stat", rx_stat, (k < 63) ? (k + 1) % 8 : 7);
      if (63 - k == 48) chk("R7 tx dma at space", tx_dma, 1);
      if (63 - k == 1) begin
        chk("R6 rx irq low", rx_irq, 0);
        chk("R7 rx dma held", rx_dma, 1);
      end
    end
    chk("R7 rx dma released empty", rx_dma, 0);
    chk("R2 tx no status", tx_stat, 0);
    chk("R2 tx data", tx_data, 8'h77);
  endtask

  task automatic t_sweep();
    for (int c = 0; c < 19; c++) begin
      int p;
      int s;
      p = (c < 4) ? 0 : c - 3;
      s = c % 4;
      prog_trig = 4'(p); trig_sel = 2'(s);
      step(0, 0, 1, 8'h00, 3'd0);
      for (int n = 1; n <= 64; n++) begin
        step(1, 0, 0, 8'(n), 3'd0);
        chk((p != 0) ? "R4 rx prog level" : "R5 rx preset level",
            rx_irq, (n >= lvl_rx(p, s)) ? 1 : 0);
        chk((p != 0) ? "R4 tx prog level" : "R5 tx preset level",
            tx_irq, (64 - n >= lvl_tx(p, s)) ? 1 : 0);
      end
    end
    step(0, 0, 1, 8'h00, 3'd0);
  endtask

  task automatic t_mode();
    for (int i = 0; i < 5; i++) step(1, 0, 0, 8'h50, 3'd0);
    chk("R11 filled", rx_cnt, 5);
    fifo_en = 1'b0;
    step(0, 0, 0, 8'h00, 3'd0);
    chk("R11 off clears", rx_cnt, 0);
    chk("R11 rx irq after clear", rx_irq, 0);
    step(1, 0, 0, 8'h61, 3'd0);
    chk("R3 holds one", rx_cnt, 1);
    fifo_en = 1'b1;
    step(1, 0, 0, 8'h62, 3'd0);
    chk("R11 on clears, push lost", rx_cnt, 0);
  endtask

  task automatic t_pair_empty();
    step(1, 1, 0, 8'h42, 3'd2);
    chk("R12 pair on empty count", rx_cnt, 1);
    chk("R12 pair on empty data kept", rx_data, 8'h77);
    step(0, 1, 0, 8'h00, 3'd0);
    chk("R13 pushed byte read", rx_data, 8'h42);
    chk("R2 pushed stat read", rx_stat, 2);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fifo_en = 1'b0; flush = 1'b0; push = 1'b0; pop = 1'b0;
    trig_sel = 2'd0; prog_trig = 4'd0; wr_data = 8'h00; wr_stat = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_disabled();
    t_pop_empty();
    t_flush();
    t_fill();
    t_sweep();
    t_mode();
    t_pair_empty();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule